// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 28 word-wide control registers that a host reaches through a simple request/write-enable bus. Most words are plain storage that software reads back unchanged. The interrupt-enable word cannot be written directly. Software sets bits through one alias and clears bits through another, and each alias keeps the last value written to it. The enable word and the interrupt-status word are read-only.

One bit of the general configuration word works as a software reset trigger. Writing it from 0 to 1 produces a single-cycle reset request for the rest of the chip. The interrupt-edge and interrupt-polarity words drive output ports so that neighbouring interrupt logic can use them.

Only full aligned words are accepted. Reads return their data one cycle after the request, with a valid flag.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset, the words read back as follows: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word reads zero.
- R2: A read sampled at a clock edge sets `bus_rvalid` and `bus_rdata` after that edge, for one cycle. A full write to any plain word (word index = byte offset >> 2, every offset 0x00..0x6C except 0x04, 0x30, 0x34, 0x38 and 0x3C) is returned by later reads.
- R3: A write to 0x30 stores the written value, which reads back at 0x30. It also sets, in the enable word at 0x38, every bit that is 1 in the written value. All other enable bits are left unchanged.
- R4: A write to 0x34 stores the written value, which reads back at 0x34. It also clears, in the enable word at 0x38, every bit that is 1 in the written value. All other enable bits are left unchanged.
- R5: Writes to 0x38 and 0x3C change nothing. The enable word changes only through 0x30 and 0x34, and 0x3C always reads zero.
- R6: A write to 0x04 stores the new value. If the write takes bit 2 of that word from 0 to 1, `reset_req` is high for exactly the one cycle after the write edge.
- R7: A write to 0x04 that leaves bit 2 at 1, or writes it as 0, raises no reset request.
- R8: An access whose byte strobes are not all four set (`bus_strb` != 4'hF), or whose address is not a multiple of 4, is ignored if it is a write. If it is a read, it returns zero with `bus_rvalid` still set.
- R9: Writes to offsets 0x70..0x7F are ignored, and reads there return zero.
- R10: `irq_edge_cfg` always equals the word at 0x24 and `irq_pol_cfg` always equals the word at 0x2C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access request, sampled each rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset into the bank |
| bus_strb | input | 4 | Byte strobes; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High for one cycle after a sampled read |
| reset_req | output | 1 | One-cycle software reset request |
| irq_edge_cfg | output | 32 | Current interrupt edge-select word |
| irq_pol_cfg | output | 32 | Current interrupt polarity word |

## Verification
The assertions assume that requests arrive only when the internal reset is released and that `bus_we`, `bus_addr`, `bus_strb` and `bus_wdata` hold steady at each sampling edge. The enable-word properties also assume that a single request is either a set or a clear, never both. The stimulus meets these assumptions. It changes inputs only on falling edges, issues one access per request cycle, and waits several cycles after reset before the first access. It exercises the set/clear aliases, the software-reset trigger and the rejected access shapes in separate phases.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int BCR_DW     = 32;
  localparam int BCR_AW     = 7;
  localparam int BCR_IW     = BCR_AW - 2;
  localparam int BCR_NREG   = 28;
  localparam int BCR_STRB_W = BCR_DW / 8;

  // word indices whose behaviour is special
  localparam int IX_GEN   = 1;
  localparam int IX_EDGE  = 9;
  localparam int IX_POL   = 11;
  localparam int IX_ENSET = 12;
  localparam int IX_ENCLR = 13;
  localparam int IX_EN    = 14;
  localparam int IX_ISR   = 15;

  localparam int RST_TRIG_BIT = 2;

  function automatic logic [BCR_DW-1:0] bcr_reset_val(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7, 8:    return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int AW   = BCR_AW,
  parameter int IW   = BCR_IW,
  parameter int SW   = BCR_STRB_W,
  parameter int NREG = BCR_NREG
) (
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] strb,
  output logic [IW-1:0] idx,
  output logic          acc_ok,
  output logic          wr_hit,
  output logic          rd_req
);
  localparam logic [IW:0] LIMIT = (IW+1)'(NREG);

  always_comb begin
    idx    = addr[AW-1:2];
    acc_ok = (strb == {SW{1'b1}}) && (addr[1:0] == 2'b00) && ({1'b0, idx} < LIMIT);
    wr_hit = req && we && acc_ok;
    rd_req = req && !we;
  end
endmodule

// File: rtl/bcr_store.sv
module bcr_store
  import bcr_pkg::*;
#(
  parameter int DW   = BCR_DW,
  parameter int IW   = BCR_IW,
  parameter int NREG = BCR_NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] regs [NREG],
  output logic          reset_req
);
  logic wr_set, wr_clr, trig_rise;

  always_comb begin
    wr_set    = wr_hit && (widx == IW'(IX_ENSET));
    wr_clr    = wr_hit && (widx == IW'(IX_ENCLR));
    trig_rise = wr_hit && (widx == IW'(IX_GEN)) &&
                !regs[IX_GEN][RST_TRIG_BIT] && wdata[RST_TRIG_BIT];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IX_ISR) begin : g_status
      assign regs[i] = '0;
    end else begin : g_store
      logic          ld;
      logic [DW-1:0] nxt;
      if (i == IX_EN) begin : g_en
        always_comb begin
          ld  = wr_set || wr_clr;
          nxt = wr_set ? (regs[i] | wdata) : (regs[i] & ~wdata);
        end
      end else begin : g_plain
        always_comb begin
          ld  = wr_hit && (widx == IW'(i));
          nxt = wdata;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs[i] <= bcr_reset_val(i);
        else if (ld) regs[i] <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= trig_rise;
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((regs[IX_EN] & $past(wdata)) == $past(wdata))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((regs[IX_EN] & $past(wdata)) == '0)); // R4
  AST_EN_ONLY_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(regs[IX_EN])); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R6
  AST_RST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> regs[IX_GEN][RST_TRIG_BIT]); // R6
endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
  import bcr_pkg::*;
#(
  parameter int DW   = BCR_DW,
  parameter int IW   = BCR_IW,
  parameter int NREG = BCR_NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          acc_ok,
  input  logic [IW-1:0] ridx,
  input  logic [DW-1:0] regs [NREG],
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] rdata_nxt;

  always_comb begin
    rdata_nxt = '0;
    if (acc_ok) rdata_nxt = regs[ridx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= rdata_nxt;
    end
  end

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !acc_ok) |=> (rvalid && rdata == '0)); // R8
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid); // R2
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
  import bcr_pkg::*;
#(
  parameter int DW   = BCR_DW,
  parameter int AW   = BCR_AW,
  parameter int SW   = BCR_STRB_W,
  parameter int NREG = BCR_NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [SW-1:0] bus_strb,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          reset_req,
  output logic [DW-1:0] irq_edge_cfg,
  output logic [DW-1:0] irq_pol_cfg
);
  localparam int IW = AW - 2;

  logic [1:0]    rst_sync;
  logic          core_rst_n;
  logic [IW-1:0] idx;
  logic          acc_ok, wr_hit, rd_req;
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  bcr_decode #(.AW(AW), .IW(IW), .SW(SW), .NREG(NREG)) u_decode (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .strb(bus_strb),
    .idx(idx), .acc_ok(acc_ok), .wr_hit(wr_hit), .rd_req(rd_req)
  );

  bcr_store #(.DW(DW), .IW(IW), .NREG(NREG)) u_store (
    .clk(clk), .rst_n(core_rst_n), .wr_hit(wr_hit), .widx(idx),
    .wdata(bus_wdata), .regs(regs), .reset_req(reset_req)
  );

  bcr_rdmux #(.DW(DW), .IW(IW), .NREG(NREG)) u_rdmux (
    .clk(clk), .rst_n(core_rst_n), .rd_req(rd_req), .acc_ok(acc_ok),
    .ridx(idx), .regs(regs), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign irq_edge_cfg = regs[IX_EDGE];
  assign irq_pol_cfg  = regs[IX_POL];

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(wr_hit && idx == IW'(IX_EDGE)) |=> $stable(irq_edge_cfg)); // R10
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(wr_hit && idx == IW'(IX_POL)) |=> $stable(irq_pol_cfg)); // R10
endmodule

// File: tb/bridge_ctl_regs_test.sv
`timescale 1ns/1ps
module bridge_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [3:0]  bus_strb = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_edge_cfg, irq_pol_cfg;
  logic        bus_rvalid, reset_req;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  bridge_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .reset_req(reset_req),
    .irq_edge_cfg(irq_edge_cfg), .irq_pol_cfg(irq_pol_cfg)
  );

  function automatic logic [31:0] init_of(input int off);
    case (off)
      'h00: return 32'h0000_0C40;
      'h04: return 32'h0000_1384;
      'h08: return 32'h2BFF_8010;
      'h0C: return 32'h255E_0091;
      'h10: return 32'h0000_6140;
      'h1C: return 32'h0000_01FF;
      'h20: return 32'h0000_01FF;
      'h68: return 32'h0000_0008;
      'h6C: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 7'(off); bus_wdata = d; bus_strb = s;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_strb = 4'hF;
  endtask

  task automatic rd(input int off, input logic [31:0] exp, input string tag, input logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 7'(off); bus_strb = s;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0; bus_strb = 4'hF;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected rvalid, actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  always @(posedge clk) if (rst_n && reset_req) pulses++;

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 rvalid idle after reset", {31'd0, bus_rvalid}, 32'd0);
    check("R6 reset_req low after reset", {31'd0, reset_req}, 32'd0);

    // R1 reset values
    for (int off = 0; off < 'h70; off += 4) rd(off, init_of(off), $sformatf("R1 init @%02h", off));
    check("R10 edge output at reset", irq_edge_cfg, 32'h0);

    // R2 plain storage
    wr('h14, 32'hA5A5_0F0F); wr('h40, 32'h1234_5678); wr('h6C, 32'h0800_0000); wr('h00, 32'hFFFF_FFFF);
    rd('h14, 32'hA5A5_0F0F, "R2 readback 14");
    rd('h40, 32'h1234_5678, "R2 readback 40");
    rd('h6C, 32'h0800_0000, "R2 readback 6C");
    rd('h00, 32'hFFFF_FFFF, "R2 readback 00");

    // R10 exported words
    wr('h24, 32'h0000_00F3); wr('h2C, 32'h8000_1234);
    @(negedge clk);
    check("R10 irq_edge_cfg", irq_edge_cfg, 32'h0000_00F3);
    check("R10 irq_pol_cfg", irq_pol_cfg, 32'h8000_1234);

    // R3 set alias
    wr('h30, 32'h0000_0011);
    rd('h30, 32'h0000_0011, "R3 set alias stored");
    rd('h38, 32'h0000_0011, "R3 enable after set");
    wr('h30, 32'h0000_0100);
    rd('h38, 32'h0000_0111, "R3 enable OR accumulate");

    // R4 clear alias
    wr('h34, 32'h0000_0010);
    rd('h34, 32'h0000_0010, "R4 clear alias stored");
    rd('h38, 32'h0000_0101, "R4 enable after clear");
    rd('h30, 32'h0000_0100, "R4 set alias unchanged");

    // R5 read-only words
    wr('h38, 32'hFFFF_FFFF);
    rd('h38, 32'h0000_0101, "R5 enable write ignored");
    wr('h3C, 32'hDEAD_BEEF);
    rd('h3C, 32'h0, "R5 status reads zero");

    // R7 no trigger: bit2 stays 1, then written 0
    wr('h04, 32'h0000_1384);
    check("R7 no pulse when bit2 already set", {31'd0, reset_req}, 32'd0);
    wr('h04, 32'h0000_1380);
    check("R7 no pulse when bit2 written 0", {31'd0, reset_req}, 32'd0);
    rd('h04, 32'h0000_1380, "R6 general word stored");
    // R6 trigger
    wr('h04, 32'h0000_1384);
    check("R6 pulse after 0->1", {31'd0, reset_req}, 32'd1);
    @(negedge clk);
    check("R6 pulse lasts one cycle", {31'd0, reset_req}, 32'd0);
    rd('h04, 32'h0000_1384, "R6 new value stored");

    // R8 malformed accesses
    wr('h14, 32'h0000_0000, 4'h3);
    rd('h14, 32'hA5A5_0F0F, "R8 partial write ignored");
    rd('h14, 32'h0, "R8 partial read zero", 4'h1);
    wr('h15, 32'h0000_0000);
    rd('h14, 32'hA5A5_0F0F, "R8 misaligned write ignored");
    rd('h15, 32'h0, "R8 misaligned read zero");

    // R9 undefined offsets
    wr('h70, 32'hCAFE_F00D); wr('h7C, 32'h1111_1111);
    rd('h70, 32'h0, "R9 read 70 zero");
    rd('h7C, 32'h0, "R9 read 7C zero");
    rd('h10, 32'h0000_6140, "R9 no alias into 10");
    rd('h1C, 32'h0000_01FF, "R9 no alias into 1C");

    repeat (3) @(negedge clk);
    check("R7 total reset pulses", pulses, 32'd1);
    check("R2 all reads returned", q_exp.size(), 32'd0);
    finish_run();
  end
endmodule